// File: doc/BRIEF.md
# Aliased Integer and Floating-Point Register File

This block holds the architectural registers of a scalar core: an integer bank of 32 words and a floating-point bank of 32 single-precision words. Each bank has two combinational read ports and one clocked write port. Integer register 0 is fixed at zero.

The floating-point bank can also be reached as 16 double-precision registers through its even indices. A single width-select input, `fpWide`, applies to every floating-point port in a cycle. In wide mode, an even index `2k` covers singles `2k` (upper half) and `2k+1` (lower half). A wide access with an odd index is not carried out. Instead, the block raises `fpMisalign`, leaves storage unchanged and returns zero on the affected read port.

A read in the same cycle as a write to the same register returns the value from before the write. The block does no forwarding and no renaming.

Top module: `aliased_regbank`

## Requirements
- R1: After reset every integer and floating-point register reads as zero.
- R2: Integer register 0 always reads zero on both ports, and any write to it is discarded.
- R3: An integer write takes effect at the clock edge. Both read ports return the new value from the next cycle onward, and a read of the same register in the write cycle returns the old value.
- R4: In narrow mode (`fpWide`=0), a write stores `fpWrData[31:0]` into single `n`. A narrow read of single `n` returns that value in bits 31:0 with bits 63:32 at zero.
- R5: In wide mode (`fpWide`=1), a write to even index `2k` stores `fpWrData[63:32]` into single `2k` and `fpWrData[31:0]` into single `2k+1`.
- R6: A wide read of even index `2k` returns {single `2k`, single `2k+1`} as a 64-bit value, including singles written one at a time in narrow mode.
- R7: When `fpWide`=1, `fpMisalign` is 1 in any cycle where either floating-point read address is odd or an enabled write has an odd address. A misaligned write changes no register, and a misaligned read port returns zero.
- R8: Writes to one bank never alter the contents of the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset, clears both banks |
| intRdAddrA | input | 5 | Integer read port A index |
| intRdDataA | output | 32 | Integer read port A data |
| intRdAddrB | input | 5 | Integer read port B index |
| intRdDataB | output | 32 | Integer read port B data |
| intWrEn | input | 1 | Integer write enable |
| intWrAddr | input | 5 | Integer write index |
| intWrData | input | 32 | Integer write data |
| fpWide | input | 1 | 1 selects 64-bit access on all floating-point ports |
| fpRdAddrA | input | 5 | Floating-point read port A index |
| fpRdDataA | output | 64 | Floating-point read port A data |
| fpRdAddrB | input | 5 | Floating-point read port B index |
| fpRdDataB | output | 64 | Floating-point read port B data |
| fpWrEn | input | 1 | Floating-point write enable |
| fpWrAddr | input | 5 | Floating-point write index |
| fpWrData | input | 64 | Floating-point write data (bits 31:0 only in narrow mode) |
| fpMisalign | output | 1 | Odd index used in a wide access |

## Verification
The bench builds the block with its default parameters: 32 integer entries, 32 floating-point entries and 32-bit words. With these values the full 5-bit index range is used, so the highest double pair (30/31) and the odd-index misalign path on both read ports and the write port can all be driven. The 32-bit word makes the overlap between the double view and the single view visible half by half, which lets the bench check the upper/lower ordering and mixed narrow-then-wide sequences directly.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic intWe;       // integer write, index nonzero
    logic fpWeFirst;   // write single at write index
    logic fpWeSecond;  // write partner single (wide, aligned)
    logic fpWide;      // wide view selected
    logic rdZeroA;     // FP port A misaligned, return zero
    logic rdZeroB;     // FP port B misaligned, return zero
  } arb_strobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl #(
  parameter int IDX_W = 5
) (
  input  logic                 intWrEn,
  input  logic [IDX_W-1:0]     intWrAddr,
  input  logic                 fpWide,
  input  logic                 fpWrEn,
  input  logic [IDX_W-1:0]     fpWrAddr,
  input  logic [IDX_W-1:0]     fpRdAddrA,
  input  logic [IDX_W-1:0]     fpRdAddrB,
  output arb_pkg::arb_strobe_t strb,
  output logic                 fpMisalign
);
  logic wrOdd, rdOddA, rdOddB;

  always_comb begin
    wrOdd  = fpWide && fpWrEn && fpWrAddr[0];
    rdOddA = fpWide && fpRdAddrA[0];
    rdOddB = fpWide && fpRdAddrB[0];

    strb.intWe      = intWrEn && (intWrAddr != '0);
    strb.fpWeFirst  = fpWrEn && !wrOdd;
    strb.fpWeSecond = fpWrEn && fpWide && !fpWrAddr[0];
    strb.fpWide     = fpWide;
    strb.rdZeroA    = rdOddA;
    strb.rdZeroB    = rdOddB;

    fpMisalign = wrOdd || rdOddA || rdOddB;
  end
endmodule

// File: rtl/arb_data.sv
module arb_data #(
  parameter int INT_REGS = 32,
  parameter int FP_REGS  = 32,
  parameter int WORD     = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  arb_pkg::arb_strobe_t        strb,
  input  logic [$clog2(INT_REGS)-1:0] intRdAddrA,
  input  logic [$clog2(INT_REGS)-1:0] intRdAddrB,
  input  logic [$clog2(INT_REGS)-1:0] intWrAddr,
  input  logic [WORD-1:0]             intWrData,
  input  logic [$clog2(FP_REGS)-1:0]  fpRdAddrA,
  input  logic [$clog2(FP_REGS)-1:0]  fpRdAddrB,
  input  logic [$clog2(FP_REGS)-1:0]  fpWrAddr,
  input  logic [2*WORD-1:0]           fpWrData,
  output logic [WORD-1:0]             intRdDataA,
  output logic [WORD-1:0]             intRdDataB,
  output logic [2*WORD-1:0]           fpRdDataA,
  output logic [2*WORD-1:0]           fpRdDataB
);
  localparam int IW = $clog2(INT_REGS);
  localparam int FW = $clog2(FP_REGS);
  localparam int DW = 2 * WORD;

  logic [WORD-1:0] intMem [INT_REGS];
  logic [WORD-1:0] fpMem  [FP_REGS];

  logic [FW-1:0] wrPartner;
  logic [WORD-1:0] firstData;

  always_comb begin
    wrPartner = {fpWrAddr[FW-1:1], 1'b1};
    firstData = strb.fpWide ? fpWrData[DW-1:WORD] : fpWrData[WORD-1:0];
  end

  // Integer bank: entry 0 is never written
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < INT_REGS; i++) intMem[i] <= '0;
    end else if (strb.intWe) begin
      intMem[intWrAddr] <= intWrData;
    end
  end

  // Floating-point bank: one or two singles per write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FP_REGS; i++) fpMem[i] <= '0;
    end else begin
      if (strb.fpWeFirst)  fpMem[fpWrAddr]  <= firstData;
      if (strb.fpWeSecond) fpMem[wrPartner] <= fpWrData[WORD-1:0];
    end
  end

  // Integer reads, index 0 forced to zero
  always_comb begin
    intRdDataA = (intRdAddrA == '0) ? '0 : intMem[intRdAddrA];
    intRdDataB = (intRdAddrB == '0) ? '0 : intMem[intRdAddrB];
  end

  // Floating-point read ports, one per generate slot
  logic [FW-1:0] rdAddr [2];
  logic          rdZero [2];
  logic [DW-1:0] rdData [2];

  always_comb begin
    rdAddr[0] = fpRdAddrA;
    rdAddr[1] = fpRdAddrB;
    rdZero[0] = strb.rdZeroA;
    rdZero[1] = strb.rdZeroB;
  end

  for (genvar p = 0; p < 2; p++) begin : g_fpRd
    logic [FW-1:0] evenIdx, oddIdx;
    always_comb begin
      evenIdx = {rdAddr[p][FW-1:1], 1'b0};
      oddIdx  = {rdAddr[p][FW-1:1], 1'b1};
      if (rdZero[p])
        rdData[p] = '0;
      else if (strb.fpWide)
        rdData[p] = {fpMem[evenIdx], fpMem[oddIdx]};
      else
        rdData[p] = {{WORD{1'b0}}, fpMem[rdAddr[p]]};
    end
  end

  always_comb begin
    fpRdDataA = rdData[0];
    fpRdDataB = rdData[1];
  end
endmodule

// File: rtl/aliased_regbank.sv
module aliased_regbank #(
  parameter int INT_REGS = 32,
  parameter int FP_REGS  = 32,
  parameter int WORD     = 32,
  localparam int IW = $clog2(INT_REGS),
  localparam int FW = $clog2(FP_REGS),
  localparam int DW = 2 * WORD
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] intRdAddrA,
  output logic [WORD-1:0] intRdDataA,
  input  logic [IW-1:0] intRdAddrB,
  output logic [WORD-1:0] intRdDataB,
  input  logic          intWrEn,
  input  logic [IW-1:0] intWrAddr,
  input  logic [WORD-1:0] intWrData,
  input  logic          fpWide,
  input  logic [FW-1:0] fpRdAddrA,
  output logic [DW-1:0] fpRdDataA,
  input  logic [FW-1:0] fpRdAddrB,
  output logic [DW-1:0] fpRdDataB,
  input  logic          fpWrEn,
  input  logic [FW-1:0] fpWrAddr,
  input  logic [DW-1:0] fpWrData,
  output logic          fpMisalign
);
  arb_pkg::arb_strobe_t strb;

  arb_ctrl #(.IDX_W(FW)) u_ctrl (
    .intWrEn    (intWrEn),
    .intWrAddr  (intWrAddr),
    .fpWide     (fpWide),
    .fpWrEn     (fpWrEn),
    .fpWrAddr   (fpWrAddr),
    .fpRdAddrA  (fpRdAddrA),
    .fpRdAddrB  (fpRdAddrB),
    .strb       (strb),
    .fpMisalign (fpMisalign)
  );

  arb_data #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .WORD(WORD)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .intRdAddrA (intRdAddrA),
    .intRdAddrB (intRdAddrB),
    .intWrAddr  (intWrAddr),
    .intWrData  (intWrData),
    .fpRdAddrA  (fpRdAddrA),
    .fpRdAddrB  (fpRdAddrB),
    .fpWrAddr   (fpWrAddr),
    .fpWrData   (fpWrData),
    .intRdDataA (intRdDataA),
    .intRdDataB (intRdDataB),
    .fpRdDataA  (fpRdDataA),
    .fpRdDataB  (fpRdDataB)
  );
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int IW = 5,
  parameter int FW = 5,
  parameter int WORD = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [IW-1:0]     intRdAddrA,
  input logic [WORD-1:0]   intRdDataA,
  input logic [IW-1:0]     intRdAddrB,
  input logic [WORD-1:0]   intRdDataB,
  input logic              intWrEn,
  input logic [IW-1:0]     intWrAddr,
  input logic [WORD-1:0]   intWrData,
  input logic              fpWide,
  input logic [FW-1:0]     fpRdAddrA,
  input logic [2*WORD-1:0] fpRdDataA,
  input logic              fpWrEn,
  input logic [FW-1:0]     fpWrAddr,
  input logic [2*WORD-1:0] fpWrData,
  input logic              fpMisalign
);
  // R2
  int_zero_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intRdAddrA == '0) |-> (intRdDataA == '0));

  // R2
  int_zero_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intRdAddrB == '0) |-> (intRdDataB == '0));

  // R3
  int_wr_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(intWrEn) && $past(intWrAddr) != '0
     && intRdAddrA == $past(intWrAddr))
    |-> (intRdDataA == $past(intWrData)));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fpWide |-> (fpRdDataA[2*WORD-1:WORD] == '0));

  // R5
  wide_low_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fpWrEn) && $past(fpWide) && !$past(fpWrAddr[0])
     && !fpWide && fpRdAddrA == {$past(fpWrAddr[FW-1:1]), 1'b1})
    |-> (fpRdDataA == {{WORD{1'b0}}, $past(fpWrData[WORD-1:0])}));

  // R6
  wide_round_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fpWrEn) && $past(fpWide) && !$past(fpWrAddr[0])
     && fpWide && fpRdAddrA == $past(fpWrAddr))
    |-> (fpRdDataA == $past(fpWrData)));

  // R7
  misalign_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fpWide && fpWrEn && fpWrAddr[0]) |-> fpMisalign);

  // R7
  misalign_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fpWide && fpRdAddrA[0]) |-> (fpMisalign && fpRdDataA == '0));
endmodule

bind aliased_regbank arb_chk #(.IW(IW), .FW(FW), .WORD(WORD)) u_chk (.*);

// File: tb/sim_aliased_regbank.sv
module sim_aliased_regbank;
  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  intRdAddrA = 0, intRdAddrB = 0, intWrAddr = 0;
  logic [31:0] intRdDataA, intRdDataB, intWrData = 0;
  logic        intWrEn = 0, fpWide = 0, fpWrEn = 0;
  logic [4:0]  fpRdAddrA = 0, fpRdAddrB = 0, fpWrAddr = 0;
  logic [63:0] fpRdDataA, fpRdDataB, fpWrData = 0;
  logic        fpMisalign;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aliased_regbank u0 (.*);

  // Vector: {req[3:0], kind[1:0], wide, addr[4:0], data[63:0]}
  // kind 0 int write, 1 int read check, 2 fp write, 3 fp read check
  localparam int NV = 15;
  localparam logic [75:0] VEC [NV] = '{
    {4'd3, 2'd0, 1'b0, 5'd5,  64'h0000_0000_1111_2222},
    {4'd3, 2'd1, 1'b0, 5'd5,  64'h0000_0000_1111_2222}, // R3
    {4'd2, 2'd0, 1'b0, 5'd0,  64'h0000_0000_DEAD_BEEF},
    {4'd2, 2'd1, 1'b0, 5'd0,  64'h0},                   // R2
    {4'd4, 2'd2, 1'b0, 5'd3,  64'h0000_0000_AAAA_0003},
    {4'd4, 2'd3, 1'b0, 5'd3,  64'h0000_0000_AAAA_0003}, // R4
    {4'd5, 2'd2, 1'b1, 5'd6,  64'h1234_5678_9ABC_DEF0},
    {4'd5, 2'd3, 1'b0, 5'd6,  64'h0000_0000_1234_5678}, // R5
    {4'd5, 2'd3, 1'b0, 5'd7,  64'h0000_0000_9ABC_DEF0}, // R5
    {4'd6, 2'd2, 1'b0, 5'd7,  64'h0000_0000_0000_0777},
    {4'd6, 2'd3, 1'b1, 5'd6,  64'h1234_5678_0000_0777}, // R6
    {4'd5, 2'd2, 1'b1, 5'd30, 64'h0102_0304_0506_0708},
    {4'd5, 2'd3, 1'b0, 5'd31, 64'h0000_0000_0506_0708}, // R5
    {4'd8, 2'd1, 1'b0, 5'd5,  64'h0000_0000_1111_2222}, // R8
    {4'd8, 2'd3, 1'b0, 5'd5,  64'h0}                    // R8
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic intWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    intWrEn = 1; intWrAddr = a; intWrData = d;
    @(negedge clk);
    intWrEn = 0;
  endtask

  task automatic fpWrite(input logic w, input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    fpWide = w; fpWrEn = 1; fpWrAddr = a; fpWrData = d;
    @(negedge clk);
    fpWrEn = 0; fpWide = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state on a spread of indices
    for (int i = 0; i < 32; i += 7) begin
      intRdAddrA = 5'(i); fpRdAddrA = 5'(i); fpWide = 0;
      #1;
      check("R1", {32'b0, intRdDataA}, 64'h0);
      check("R1", fpRdDataA, 64'h0);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [3:0] rq;
      logic [1:0] kind;
      logic       w;
      logic [4:0] a;
      logic [63:0] d;
      string tag;
      {rq, kind, w, a, d} = VEC[v];
      tag = $sformatf("R%0d", rq);
      case (kind)
        2'd0: intWrite(a, d[31:0]);
        2'd2: fpWrite(w, a, d);
        2'd1: begin
          @(negedge clk);
          intRdAddrA = a; intRdAddrB = a;
          #1;
          check(tag, {32'b0, intRdDataA}, d);
          check(tag, {32'b0, intRdDataB}, d);
        end
        default: begin
          @(negedge clk);
          fpWide = w; fpRdAddrA = a; fpRdAddrB = a;
          #1;
          check(tag, fpRdDataA, d);
          check(tag, fpRdDataB, d);
          fpWide = 0;
        end
      endcase
    end

    // R3: same-cycle read returns old value, new value after the edge
    @(negedge clk);
    intWrEn = 1; intWrAddr = 5'd9; intWrData = 32'hCAFE_0009;
    intRdAddrA = 5'd9; intRdAddrB = 5'd9;
    #1;
    check("R3", {32'b0, intRdDataA}, 64'h0);
    @(negedge clk);
    intWrEn = 0;
    #1;
    check("R3", {32'b0, intRdDataB}, 64'h0000_0000_CAFE_0009);

    // R8: int write leaves FP single 9 untouched
    @(negedge clk);
    fpRdAddrA = 5'd9;
    #1;
    check("R8", fpRdDataA, 64'h0);

    // R7: misaligned wide write flagged and discarded
    fpWrite(1'b0, 5'd8, 64'h0000_0000_8888_8888);
    @(negedge clk);
    fpWide = 1; fpWrEn = 1; fpWrAddr = 5'd9; fpWrData = 64'hFFFF_FFFF_EEEE_EEEE;
    fpRdAddrA = 5'd8; fpRdAddrB = 5'd8;
    #1;
    check("R7", {63'b0, fpMisalign}, 64'h1);
    @(negedge clk);
    fpWrEn = 0; fpWide = 0;
    #1;
    check("R7", {63'b0, fpMisalign}, 64'h0);
    fpRdAddrA = 5'd9; fpRdAddrB = 5'd10;
    #1;
    check("R7", fpRdDataA, 64'h0);
    check("R7", fpRdDataB, 64'h0);
    fpRdAddrA = 5'd8;
    #1;
    check("R7", fpRdDataA, 64'h0000_0000_8888_8888);

    // R7: misaligned read port returns zero, aligned port unaffected
    @(negedge clk);
    fpWide = 1; fpRdAddrA = 5'd7; fpRdAddrB = 5'd6;
    #1;
    check("R7", {63'b0, fpMisalign}, 64'h1);
    check("R7", fpRdDataA, 64'h0);
    check("R6", fpRdDataB, 64'h1234_5678_0000_0777);
    fpWide = 0;

    // R8: FP wide write leaves integer register 30 at zero
    intRdAddrA = 5'd30;
    #1;
    check("R8", {32'b0, intRdDataA}, 64'h0);

    // R1: reset clears written contents
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    intRdAddrA = 5'd5; fpWide = 1; fpRdAddrA = 5'd6;
    #1;
    check("R1", {32'b0, intRdDataA}, 64'h0);
    check("R1", fpRdDataA, 64'h0);
    fpWide = 0;

    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule